// File: doc/BRIEF.md
# Rotating Event-Flag Interrupt Scanner

This block keeps a pending-event flag for every line and event kind of a 32-line terminal multiplexer, with four kinds per line: character received, transmit done, carrier gained and carrier lost. A rotating pointer hunts through the flags one entry per clock and halts on the first pending one it meets. It then locks and raises the interrupt level that matches the event kind. The processor services the event by reading: the read clears the flag under the pointer, releases the lock and starts the next hunt from the entry after the one just served. Every source therefore gets a fair turn.

Event pulses that arrive while the scanner is locked or hunting are still stored, and a later hunt picks them up. Each interrupt level stays raised until its own acknowledge pulse. The number of lines is a parameter and must be a power of two.

Top module: `evscan_top`

## Requirements
- R1: A pulse on bit `line*4 + kind` of `set_pulse` records a pending flag for that line and kind. The flag persists until a processor read clears it.
- R2: The pointer is shown as `scan_line` (its upper bits) and `scan_kind` (its low 2 bits). Kind codes are 0 = receive, 1 = transmit done, 2 = carrier on, 3 = carrier off.
- R3: A hunt begins at the entry one past the pointer and advances the pointer by one entry per clock, wrapping modulo 128. `scan_busy` is high while it runs, and it stops at the first pending flag.
- R4: When a hunt finds a flag, on that same edge `scan_locked` goes high, `scan_busy` goes low and `irq_req[scan_kind]` is set.
- R5: While locked, the pointer holds and no hunt starts, but new pulses are still recorded. A read while not locked has no effect.
- R6: A read while locked clears the flag at the pointer and drops the lock. A new hunt runs from the next edge.
- R7: A hunt that visits 128 entries without a hit ends idle and unlocked, with the pointer back at its starting value.
- R8: Each `irq_req` bit stays high until its `irq_ack` bit is pulsed. If a raise and an acknowledge of the same level fall in one cycle, the level stays high.
- R9: A set pulse on the index being cleared by a read wins. A set pulse on any other index in that cycle is kept.
- R10: Reset (`rst_n` low) clears all flags, the pointer, the lock, the busy state and all interrupt requests.
- R11: When idle and unlocked with any flag pending, a hunt starts on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse | input | 128 | One flag-set pulse per line and kind, index line*4+kind |
| cpu_rd | input | 1 | Processor read strobe |
| irq_ack | input | 4 | Acknowledge, one bit per interrupt level |
| scan_line | output | 5 | Line field of the pointer |
| scan_kind | output | 2 | Event kind field of the pointer |
| scan_locked | output | 1 | Scanner is holding a found flag |
| scan_busy | output | 1 | Hunt in progress |
| irq_req | output | 4 | Interrupt request per level |

## Verification
A single flag set from reset shows the hunt latency and where the pointer stops. Several flags on both sides of the pointer show that service follows rotation order and not index order. A read that lands in the same cycle as a set pulse shows which operation wins, both for the same index and for another one. The read that empties the array exercises the full 128-step pass. A long stretch of random pulses, reads and acknowledges is compared against a behavioural model on every clock, which separates ordering, lock holding and level-hold faults.

// File: rtl/evscan_pkg.sv
package evscan_pkg;

    localparam int KIND_W = 2;
    localparam int KINDS  = 1 << KIND_W;

    typedef enum logic [KIND_W-1:0] {
        EV_RX       = 2'd0,
        EV_TX_DONE  = 2'd1,
        EV_CARR_ON  = 2'd2,
        EV_CARR_OFF = 2'd3
    } evt_kind_e;

endpackage

// File: rtl/evscan_flags.sv
module evscan_flags #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     set_pulse,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     flags
);

    logic [N-1:0] flags_d, flags_q;

    // Per-entry next value: a set pulse dominates a clear of the same entry.
    for (genvar i = 0; i < N; i++) begin : g_entry
        always_comb begin
            flags_d[i] = flags_q[i];
            if (clr_en && (clr_idx == IDX_W'(i)))
                flags_d[i] = 1'b0;
            if (set_pulse[i])
                flags_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/evscan_irq.sv
module evscan_irq #(
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_en,
    input  logic [LVL_W-1:0]  raise_lvl,
    input  logic [LEVELS-1:0] ack,
    output logic [LEVELS-1:0] irq
);

    logic [LEVELS-1:0] irq_d, irq_q;

    // A raise in the same cycle as an acknowledge of that level keeps it set.
    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        always_comb begin
            irq_d[l] = irq_q[l] & ~ack[l];
            if (raise_en && (raise_lvl == LVL_W'(l)))
                irq_d[l] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/evscan_top.sv
module evscan_top
    import evscan_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LINES*KINDS-1:0]             set_pulse,
    input  logic                               cpu_rd,
    input  logic [KINDS-1:0]                   irq_ack,
    output logic [$clog2(LINES)-1:0]           scan_line,
    output logic [KIND_W-1:0]                  scan_kind,
    output logic                               scan_locked,
    output logic                               scan_busy,
    output logic [KINDS-1:0]                   irq_req
);

    localparam int LINE_W = $clog2(LINES);
    localparam int NFLAGS = LINES * KINDS;
    localparam int IDX_W  = LINE_W + KIND_W;
    localparam int CNT_W  = IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [CNT_W-1:0] steps;
        logic             locked;
        logic             busy;
    } scan_st_t;

    scan_st_t         st_d, st_q;
    logic [NFLAGS-1:0] flags;
    logic [IDX_W-1:0]  cand;
    logic              raise_en;
    logic              clr_en;
    evt_kind_e         raise_kind;

    evscan_flags #(
        .N     (NFLAGS),
        .IDX_W (IDX_W)
    ) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .clr_en    (clr_en),
        .clr_idx   (st_q.ptr),
        .flags     (flags)
    );

    evscan_irq #(
        .LEVELS (KINDS),
        .LVL_W  (KIND_W)
    ) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_en  (raise_en),
        .raise_lvl (raise_kind),
        .ack       (irq_ack),
        .irq       (irq_req)
    );

    always_comb begin
        st_d       = st_q;
        raise_en   = 1'b0;
        clr_en     = 1'b0;
        cand       = st_q.ptr + 1'b1;
        raise_kind = evt_kind_e'(cand[KIND_W-1:0]);

        if (st_q.busy) begin
            // One candidate entry per clock.
            st_d.ptr = cand;
            if (flags[cand]) begin
                st_d.locked = 1'b1;
                st_d.busy   = 1'b0;
                raise_en    = 1'b1;
            end else begin
                st_d.steps = st_q.steps + 1'b1;
                if (st_q.steps == {CNT_W{1'b1}})
                    st_d.busy = 1'b0;
            end
        end else if (st_q.locked) begin
            if (cpu_rd) begin
                clr_en      = 1'b1;
                st_d.locked = 1'b0;
                st_d.busy   = 1'b1;
                st_d.steps  = '0;
            end
        end else if (|flags) begin
            st_d.busy  = 1'b1;
            st_d.steps = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan_line   = st_q.ptr[IDX_W-1:KIND_W];
    assign scan_kind   = st_q.ptr[KIND_W-1:0];
    assign scan_locked = st_q.locked;
    assign scan_busy   = st_q.busy;

endmodule

// File: rtl/evscan_chk.sv
module evscan_chk #(
    parameter int LINES = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cpu_rd,
    input logic [3:0]               irq_ack,
    input logic [$clog2(LINES)-1:0] scan_line,
    input logic [1:0]               scan_kind,
    input logic                     scan_locked,
    input logic                     scan_busy,
    input logic [3:0]               irq_req
);

    localparam int IDX_W = $clog2(LINES) + 2;

    logic [IDX_W-1:0] ptr;
    assign ptr = {scan_line, scan_kind};

    // R4: found and hunting are never both reported
    a_r4_lock_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_locked && scan_busy));

    // R4: the level of the found kind is raised when the lock is taken
    a_r4_raise_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_locked) |-> irq_req[scan_kind]);

    // R3: each hunt cycle moves the pointer by exactly one entry
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |=> (ptr == $past(ptr) + 1'b1));

    // R5: without a read the lock and the pointer hold
    a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_locked && !cpu_rd) |=> (scan_locked && $stable(ptr)));

    // R6: a read while locked releases the lock and starts a hunt
    a_r6_read_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_locked && cpu_rd) |=> (!scan_locked && scan_busy));

    // R7: an idle, unlocked scanner leaves the pointer alone
    a_r7_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy && !scan_locked) |=> $stable(ptr));

    // R8: a raised level without acknowledge stays raised
    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_req & ~irq_ack)) |=>
            ((irq_req & $past(irq_req & ~irq_ack)) == $past(irq_req & ~irq_ack)));

endmodule

bind evscan_top evscan_chk #(.LINES(LINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .irq_ack     (irq_ack),
    .scan_line   (scan_line),
    .scan_kind   (scan_kind),
    .scan_locked (scan_locked),
    .scan_busy   (scan_busy),
    .irq_req     (irq_req)
);

// File: tb/evscan_top_tb_top.sv
module evscan_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] set_pulse = '0;
    logic         cpu_rd = 1'b0;
    logic [3:0]   irq_ack = '0;
    logic [4:0]   scan_line;
    logic [1:0]   scan_kind;
    logic         scan_locked;
    logic         scan_busy;
    logic [3:0]   irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit [127:0] mf;
    int         mptr, msteps;
    bit         mlock, mbusy;
    bit [3:0]   mirq;

    always #4 clk = ~clk;

    evscan_top dut_i (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .cpu_rd(cpu_rd),
        .irq_ack(irq_ack), .scan_line(scan_line), .scan_kind(scan_kind),
        .scan_locked(scan_locked), .scan_busy(scan_busy), .irq_req(irq_req)
    );

    function automatic bit [127:0] bit_at(input int i);
        return 128'(1) << i;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_upd();
        bit [127:0] nf;
        bit hit;
        if (!rst_n) begin
            mf = '0; mptr = 0; msteps = 0; mlock = 0; mbusy = 0; mirq = '0;
            return;
        end
        hit = mbusy && mf[(mptr + 1) % 128];
        nf = mf;
        if (mlock && cpu_rd) nf[mptr] = 1'b0;
        nf = nf | set_pulse;
        mirq = mirq & ~irq_ack;
        if (mbusy) begin
            mptr = (mptr + 1) % 128;
            if (hit) begin
                mlock = 1; mbusy = 0; mirq[mptr % 4] = 1'b1;
            end else begin
                msteps++;
                if (msteps == 128) mbusy = 0;
            end
        end else if (mlock) begin
            if (cpu_rd) begin mlock = 0; mbusy = 1; msteps = 0; end
        end else if (mf != '0) begin
            mbusy = 1; msteps = 0;
        end
        mf = nf;
    endtask

    task automatic compare();
        chk(int'({scan_line, scan_kind}) == mptr, "R3 pointer", int'({scan_line, scan_kind}), mptr);
        chk(scan_busy == mbusy, "R3 busy", scan_busy, mbusy);
        chk(scan_locked == mlock, "R4 locked", scan_locked, mlock);
        chk(irq_req == mirq, "R8 irq", irq_req, mirq);
    endtask

    // drive at a falling edge, update model at the rising edge, sample at the next falling edge
    task automatic step(input bit [127:0] s, input bit r, input bit [3:0] a);
        set_pulse = s; cpu_rd = r; irq_ack = a;
        @(posedge clk);
        model_upd();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_lock();
        for (int n = 0; n < 300 && !scan_locked; n++) step('0, 0, '0);
    endtask

    initial begin
        int saved;
        @(negedge clk);
        step('0, 0, '0);
        step('0, 0, '0);
        rst_n = 1'b1;
        step('0, 0, '0);
        // R10: reset state
        chk(scan_line == 0 && scan_kind == 0, "R10 ptr", {scan_line, scan_kind}, 0);
        chk(!scan_locked && !scan_busy && irq_req == 0, "R10 state", {scan_locked, scan_busy, irq_req}, 0);

        // R1 / R11: line 5 carrier on -> index 22
        step(bit_at(22), 0, '0);
        chk(!scan_busy, "R11 not yet", scan_busy, 0);
        step('0, 0, '0);
        chk(scan_busy, "R11 hunt starts", scan_busy, 1);
        step('0, 0, '0);
        chk({scan_line, scan_kind} == 7'd1, "R3 first candidate", {scan_line, scan_kind}, 1);
        wait_lock();
        chk(scan_line == 5, "R1 line", scan_line, 5);
        chk(scan_kind == 2, "R2 kind carrier on", scan_kind, 2);
        chk(irq_req == 4'b0100, "R4 level", irq_req, 4);

        // R5: new events while locked are stored, pointer holds
        step(bit_at(3) | bit_at(100), 0, '0);
        step('0, 0, '0);
        step('0, 0, '0);
        chk(scan_locked && {scan_line, scan_kind} == 7'd22, "R5 hold", {scan_line, scan_kind}, 22);
        step('0, 0, 4'b0100);
        chk(irq_req == 4'b0000, "R8 ack clears", irq_req, 0);
        chk(scan_locked, "R5 ack keeps lock", scan_locked, 1);

        // R6: read restarts from 23; rotation finds 100 before 3
        step('0, 1, '0);
        chk(!scan_locked && scan_busy, "R6 unlock", {scan_locked, scan_busy}, 1);
        wait_lock();
        chk({scan_line, scan_kind} == 7'd100, "R6 next found", {scan_line, scan_kind}, 100);
        chk(scan_line == 25 && scan_kind == 0, "R2 receive", {scan_line, scan_kind}, 100);

        // R9: set same index as clear, plus another index, with the read
        step(bit_at(100) | bit_at(50), 1, '0);
        wait_lock();
        chk({scan_line, scan_kind} == 7'd3, "R3 wrap order", {scan_line, scan_kind}, 3);
        chk(irq_req == 4'b1001, "R8 held", irq_req, 9);
        step('0, 1, '0);
        wait_lock();
        chk({scan_line, scan_kind} == 7'd50, "R9 other index kept", {scan_line, scan_kind}, 50);
        step('0, 1, '0);
        wait_lock();
        chk({scan_line, scan_kind} == 7'd100, "R9 same index set wins", {scan_line, scan_kind}, 100);

        // R7: empty pass
        saved = int'({scan_line, scan_kind});
        step('0, 1, '0);
        for (int k = 0; k < 127; k++) step('0, 0, '0);
        chk(scan_busy, "R7 still hunting", scan_busy, 1);
        step('0, 0, '0);
        chk(!scan_busy && !scan_locked, "R7 idle", {scan_busy, scan_locked}, 0);
        chk(int'({scan_line, scan_kind}) == saved, "R7 ptr back", {scan_line, scan_kind}, saved);

        // R5: read while idle ignored
        step('0, 1, '0);
        step('0, 0, '0);
        chk(!scan_busy && !scan_locked && int'({scan_line, scan_kind}) == saved,
            "R5 idle read", {scan_busy, scan_locked}, 0);
        step('0, 0, 4'b1111);
        chk(irq_req == 0, "R8 ack all", irq_req, 0);

        // R8: raise and ack of the same level together
        step(bit_at(101), 0, '0);
        step('0, 0, '0);
        step('0, 0, 4'b0010);
        chk(scan_locked && irq_req == 4'b0010, "R8 raise beats ack", irq_req, 2);

        // R10: reset mid operation
        step(bit_at(7) | bit_at(90), 0, '0);
        rst_n = 1'b0;
        step('0, 0, '0);
        rst_n = 1'b1;
        chk(irq_req == 0 && !scan_locked && {scan_line, scan_kind} == 0, "R10 mid reset",
            {irq_req, scan_locked}, 0);
        for (int k = 0; k < 4; k++) step('0, 0, '0);
        chk(!scan_busy, "R10 flags gone", scan_busy, 0);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            bit [127:0] s = '0;
            if ($urandom_range(3) == 0) s = bit_at($urandom_range(127));
            if ($urandom_range(9) == 0) s = s | bit_at($urandom_range(127));
            step(s, $urandom_range(5) == 0, ($urandom_range(3) == 0) ? 4'($urandom) : 4'b0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule